// File: doc/BRIEF.md
# Sliding-Window Complex Interference Canceller

This block removes from a main complex signal the part that is correlated with an auxiliary complex reference. Both streams arrive as one sample pair at a time, with signed real and imaginary parts. For every accepted pair the block keeps running sums over the nine most recent pairs. One sum is the cross-correlation of main with the conjugate of auxiliary. The other is the auxiliary power, which is purely real. From these sums it derives a complex weight in fixed point, and it outputs the residual: the main sample minus the weight times the auxiliary sample of the same pair.

The weight is formed fresh for every sample. Each of its two components comes from a restoring divider that works one bit per cycle, and the two dividers run side by side. While they are working the block drops its ready output and takes no new pair. Every result therefore arrives a fixed number of cycles after its pair was accepted. Results are flagged valid only once nine pairs have entered the window.

Top module: `iq_canceller`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high, and `res_re`, `res_im`, `wt_re` and `wt_im` are all zero.
- R2: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low on the next cycle and stays low until the result of that pair is out. Pairs offered while `in_ready` is low have no effect on any later output.
- R3: No `out_valid` follows the first eight accepted pairs. From the ninth accepted pair on, each accepted pair gives exactly one single-cycle `out_valid` pulse.
- R4: Let N be the sum, over the last nine accepted pairs, of m·conj(a), where the real part is mr·ar+mi·ai and the imaginary part is mi·ar−mr·ai. Let P be the sum over the same pairs of ar²+ai². Each weight component equals N_x·2^FRAC/P, truncated toward zero (FRAC fraction bits, two's complement).
- R5: When P is zero, both weight components are zero and the residual equals the main sample.
- R6: Let e_re = wt_re·ar − wt_im·ai and e_im = wt_re·ai + wt_im·ar. Then res_re = mr − floor(e_re/2^FRAC) and res_im = mi − floor(e_im/2^FRAC), both taken on the pair just accepted.
- R7: A pair that is more than nine acceptances old no longer contributes to N or P.
- R8: `out_valid` for a pair, and the return of `in_ready`, come exactly FRAC+2·DW+8 rising edges after the acceptance edge.
- R9: Full-scale inputs, including −2^(DW−1) on every component, give exact R4 and R6 results without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample pair is offered |
| main_re | input | DW | Main sample, real part, signed |
| main_im | input | DW | Main sample, imaginary part, signed |
| aux_re | input | DW | Auxiliary sample, real part, signed |
| aux_im | input | DW | Auxiliary sample, imaginary part, signed |
| in_ready | output | 1 | High when a pair can be accepted |
| out_valid | output | 1 | Single-cycle pulse marking a valid residual |
| res_re | output | DW+4 | Residual, real part, signed |
| res_im | output | DW+4 | Residual, imaginary part, signed |
| wt_re | output | 2·DW+FRAC+6 | Weight, real part, signed, FRAC fraction bits |
| wt_im | output | 2·DW+FRAC+6 | Weight, imaginary part, signed, FRAC fraction bits |

## Verification
The assertions run on every cycle and cover the handshake timing: ready drops after each acceptance and stays low for the whole divide, results land at the fixed latency as single pulses, and no result appears before the window is full. They also check that the two divider lanes finish together and that the zero-power case passes the main sample through. Only the bench's scenarios can show that the numbers are right. A behavioural model compares the weights and residuals against random data, against a main channel that is an exact multiple of the auxiliary, against a window that has been flushed to zero power, and against full-scale negative values. The same scenarios show that pairs offered while busy are discarded.

// File: rtl/iqc_pkg.sv
// Shared types for the sliding-window complex interference canceller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package iqc_pkg;

    // Sequencing states of the canceller top level
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a sample pair
        ST_KICK = 2'd1,   // sums settled, dividers launched
        ST_WAIT = 2'd2    // dividers iterating
    } state_e;

endpackage

// File: rtl/iqc_conj_mul.sv
// Conjugate cross product and auxiliary power of one sample pair.
// Computes m*conj(a) with four real multiplies, plus |a|^2.
// Assumes two's-complement inputs of DW bits; outputs are exact in 2*DW+1 bits.
module iqc_conj_mul #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0]   m_re,
    input  logic signed [DW-1:0]   m_im,
    input  logic signed [DW-1:0]   a_re,
    input  logic signed [DW-1:0]   a_im,
    output logic signed [2*DW:0]   p_re,
    output logic signed [2*DW:0]   p_im,
    output logic signed [2*DW:0]   p_pw
);
    localparam int MW = 2 * DW;
    localparam int PW = MW + 1;

    logic signed [MW-1:0] xm_re, xm_im, xa_re, xa_im;
    logic signed [MW-1:0] t_rr, t_ii, t_ir, t_ri, t_aa, t_bb;

    // Widen operands so each product is formed at full precision
    always_comb begin
        xm_re = {{DW{m_re[DW-1]}}, m_re};
        xm_im = {{DW{m_im[DW-1]}}, m_im};
        xa_re = {{DW{a_re[DW-1]}}, a_re};
        xa_im = {{DW{a_im[DW-1]}}, a_im};
    end

    // The four cross products and two squares
    always_comb begin
        t_rr = xm_re * xa_re;
        t_ii = xm_im * xa_im;
        t_ir = xm_im * xa_re;
        t_ri = xm_re * xa_im;
        t_aa = xa_re * xa_re;
        t_bb = xa_im * xa_im;
    end

    // Combine into the conjugate product and the power, one guard bit each
    always_comb begin
        p_re = PW'({t_rr[MW-1], t_rr}) + PW'({t_ii[MW-1], t_ii});
        p_im = PW'({t_ir[MW-1], t_ir}) - PW'({t_ri[MW-1], t_ri});
        p_pw = PW'({t_aa[MW-1], t_aa}) + PW'({t_bb[MW-1], t_bb});
    end

endmodule

// File: rtl/iqc_window.sv
// Sliding-window accumulator for three product streams.
// Each push enters a new product and retires the one WIN pushes old.
// Assumes AW-PW guard bits are enough for WIN terms; the delay line resets to zero.
module iqc_window #(
    parameter int PW  = 25,
    parameter int AW  = 29,
    parameter int WIN = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [PW-1:0] x_re,
    input  logic signed [PW-1:0] x_im,
    input  logic signed [PW-1:0] x_pw,
    output logic signed [AW-1:0] acc_re,
    output logic signed [AW-1:0] acc_im,
    output logic signed [AW-1:0] acc_pw,
    output logic                 full
);
    localparam int NL = 3;
    localparam int CW = $clog2(WIN + 1);
    localparam int EW = AW - PW;

    logic signed [PW-1:0] x_arr   [NL];
    logic signed [AW-1:0] acc_arr [NL];
    logic [CW-1:0]        fill_q;

    // Gather the three streams so one lane template serves them all
    always_comb begin
        x_arr[0] = x_re;
        x_arr[1] = x_im;
        x_arr[2] = x_pw;
    end

    assign acc_re = acc_arr[0];
    assign acc_im = acc_arr[1];
    assign acc_pw = acc_arr[2];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic signed [PW-1:0] line_q [WIN];
        logic signed [AW-1:0] sum_q;
        logic signed [AW-1:0] add_x, sub_x;

        // Sign-extend the entering and leaving terms
        always_comb begin
            add_x = {{EW{x_arr[g][PW-1]}}, x_arr[g]};
            sub_x = {{EW{line_q[WIN-1][PW-1]}}, line_q[WIN-1]};
        end

        // Shift the delay line and slide the running sum
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WIN; i++) line_q[i] <= '0;
                sum_q <= '0;
            end else if (push) begin
                line_q[0] <= x_arr[g];
                for (int i = 1; i < WIN; i++) line_q[i] <= line_q[i-1];
                sum_q <= sum_q + add_x - sub_x;
            end
        end

        assign acc_arr[g] = sum_q;
    end

    // Count pushes until the window has been filled once
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (push && fill_q != CW'(WIN))
            fill_q <= fill_q + CW'(1);
    end

    assign full = (fill_q == CW'(WIN));

endmodule

// File: rtl/iqc_divider.sv
// Unsigned restoring divider, one quotient bit per clock.
// A start pulse loads the operands; done pulses for one cycle NW cycles later,
// and the quotient holds until the next start. A zero divisor yields a zero quotient.
// Assumes start is not raised while a division is running.
module iqc_divider #(
    parameter int NW  = 39,
    parameter int DVW = 29
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic [NW-1:0]  quotient,
    output logic           done
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0]  dq_q;
    logic [DVW-1:0] rem_q, dvs_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q, zero_q;
    logic [DVW:0]   trial, diff;
    logic           fits;
    logic           unused_diff;

    // Trial subtraction for the current quotient bit
    always_comb begin
        trial = {rem_q, dq_q[NW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    assign unused_diff = diff[DVW];

    // Load, iterate and finish the division
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q   <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            zero_q <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dq_q   <= dividend;
                rem_q  <= '0;
                dvs_q  <= divisor;
                zero_q <= (divisor == '0);
                cnt_q  <= CW'(NW);
                run_q  <= 1'b1;
            end else if (run_q) begin
                dq_q  <= {dq_q[NW-2:0], fits};
                rem_q <= fits ? diff[DVW-1:0] : trial[DVW-1:0];
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = zero_q ? '0 : dq_q;

endmodule

// File: rtl/iq_canceller.sv
// Sliding-window complex interference canceller, top level.
// Per accepted pair: updates windowed sums of m*conj(a) and |a|^2, divides each
// numerator component by the power in a restoring divider, then outputs
// main - w*aux for the same pair. One pair is in flight at a time; in_ready
// is low while the dividers work. Assumes synchronous active-low reset.
module iq_canceller #(
    parameter int DW   = 12,
    parameter int FRAC = 10,
    parameter int WIN  = 9,
    parameter int OW   = DW + 4,
    parameter int WW   = 2 * DW + 6 + FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] main_re,
    input  logic signed [DW-1:0] main_im,
    input  logic signed [DW-1:0] aux_re,
    input  logic signed [DW-1:0] aux_im,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic signed [OW-1:0] res_re,
    output logic signed [OW-1:0] res_im,
    output logic signed [WW-1:0] wt_re,
    output logic signed [WW-1:0] wt_im
);
    import iqc_pkg::*;

    localparam int PW  = 2 * DW + 1;
    localparam int AW  = PW + $clog2(WIN);
    localparam int NQ  = AW + FRAC;
    localparam int PRW = WW + DW + 1;

    state_e               st_q;
    logic                 accept;
    logic signed [DW-1:0] hold_mr, hold_mi, hold_ar, hold_ai;
    logic signed [PW-1:0] prod_re, prod_im, prod_pw;
    logic signed [AW-1:0] acc_re, acc_im, acc_pw;
    logic                 win_full;
    logic                 div_start;
    logic [AW-1:0]        den;
    logic signed [AW-1:0] num_s   [2];
    logic [AW-1:0]        num_mag [2];
    logic [NQ-1:0]        dvd     [2];
    logic [NQ-1:0]        quo     [2];
    logic signed [WW-1:0] wt_w    [2];
    logic [1:0]           div_done;

    assign in_ready  = (st_q == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign div_start = (st_q == ST_KICK);

    // Sequence one pair through sum update, division and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (in_valid) st_q <= ST_KICK;
                ST_KICK: st_q <= ST_WAIT;
                ST_WAIT: if (div_done[0]) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Keep the accepted pair until its weight is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_mr <= '0;
            hold_mi <= '0;
            hold_ar <= '0;
            hold_ai <= '0;
        end else if (accept) begin
            hold_mr <= main_re;
            hold_mi <= main_im;
            hold_ar <= aux_re;
            hold_ai <= aux_im;
        end
    end

    iqc_conj_mul #(.DW(DW)) u_cmul (
        .m_re (main_re),
        .m_im (main_im),
        .a_re (aux_re),
        .a_im (aux_im),
        .p_re (prod_re),
        .p_im (prod_im),
        .p_pw (prod_pw)
    );

    iqc_window #(.PW(PW), .AW(AW), .WIN(WIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (accept),
        .x_re   (prod_re),
        .x_im   (prod_im),
        .x_pw   (prod_pw),
        .acc_re (acc_re),
        .acc_im (acc_im),
        .acc_pw (acc_pw),
        .full   (win_full)
    );

    assign num_s[0] = acc_re;
    assign num_s[1] = acc_im;
    assign den      = acc_pw;

    for (genvar g = 0; g < 2; g++) begin : g_div
        // Magnitude of the numerator, scaled up by the fraction bits
        assign num_mag[g] = num_s[g][AW-1] ? -num_s[g] : num_s[g];
        assign dvd[g]     = {num_mag[g], {FRAC{1'b0}}};

        iqc_divider #(.NW(NQ), .DVW(AW)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (div_start),
            .dividend (dvd[g]),
            .divisor  (den),
            .quotient (quo[g]),
            .done     (div_done[g])
        );

        // Restore the numerator sign on the quotient
        assign wt_w[g] = num_s[g][AW-1] ? -$signed({1'b0, quo[g]})
                                        :  $signed({1'b0, quo[g]});
    end

    logic signed [PRW-1:0] wr_x, wi_x, ar_x, ai_x, mr_x, mi_x;
    logic signed [PRW-1:0] est_re, est_im, rr_re, rr_im;
    logic                  unused_rr;

    // Apply the weight to the held auxiliary sample and cancel
    always_comb begin
        wr_x   = {{(PRW-WW){wt_w[0][WW-1]}}, wt_w[0]};
        wi_x   = {{(PRW-WW){wt_w[1][WW-1]}}, wt_w[1]};
        ar_x   = {{(PRW-DW){hold_ar[DW-1]}}, hold_ar};
        ai_x   = {{(PRW-DW){hold_ai[DW-1]}}, hold_ai};
        mr_x   = {{(PRW-DW){hold_mr[DW-1]}}, hold_mr};
        mi_x   = {{(PRW-DW){hold_mi[DW-1]}}, hold_mi};
        est_re = wr_x * ar_x - wi_x * ai_x;
        est_im = wr_x * ai_x + wi_x * ar_x;
        rr_re  = mr_x - (est_re >>> FRAC);
        rr_im  = mi_x - (est_im >>> FRAC);
    end

    assign unused_rr = ^{rr_re[PRW-1:OW], rr_im[PRW-1:OW]};

    // Register the result when the dividers finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_re    <= '0;
            res_im    <= '0;
            wt_re     <= '0;
            wt_im     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (div_done[0]) begin
                out_valid <= win_full;
                res_re    <= rr_re[OW-1:0];
                res_im    <= rr_im[OW-1:0];
                wt_re     <= wt_w[0];
                wt_im     <= wt_w[1];
            end
        end
    end

endmodule

// Property checker for iq_canceller, attached by bind below.
// Tracks acceptances and cycles since the last one with small counters.
module iqc_checker #(
    parameter int DW   = 12,
    parameter int FRAC = 10,
    parameter int WIN  = 9,
    parameter int OW   = DW + 4,
    parameter int WW   = 2 * DW + 6 + FRAC,
    parameter int AW   = 2 * DW + 1 + $clog2(WIN)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic signed [OW-1:0] res_re,
    input logic signed [OW-1:0] res_im,
    input logic signed [WW-1:0] wt_re,
    input logic signed [WW-1:0] wt_im,
    input logic signed [DW-1:0] hold_mr,
    input logic signed [DW-1:0] hold_mi,
    input logic signed [AW-1:0] pw_sum,
    input logic                 done0,
    input logic                 done1
);
    localparam int NQ  = AW + FRAC;
    localparam int LAT = NQ + 3;
    localparam int LW  = $clog2(LAT + 1);
    localparam int NW  = $clog2(WIN + 1);
    localparam logic [LW-1:0] LAT_C = LW'(LAT);
    localparam logic [NW-1:0] WIN_C = NW'(WIN);

    logic          acc_ev;
    logic [LW-1:0] lat_q;
    logic [NW-1:0] nacc_q;

    assign acc_ev = in_valid && in_ready;

    // Cycles since the last acceptance, held at the latency mark
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (acc_ev)
            lat_q <= LW'(1);
        else if (lat_q != '0 && lat_q != LAT_C)
            lat_q <= lat_q + LW'(1);
    end

    // Acceptances so far, held at the window size
    always_ff @(posedge clk) begin
        if (!rst_n)
            nacc_q <= '0;
        else if (acc_ev && nacc_q != WIN_C)
            nacc_q <= nacc_q + NW'(1);
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ev |=> !in_ready);

    // R8
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q != '0 && lat_q < LAT_C) |-> !in_ready);

    // R8
    result_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == LAT_C));

    // R3
    early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nacc_q == WIN_C));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    lane_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done0 |-> done1);

    // R5
    zero_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pw_sum == '0) |->
            (wt_re == '0 && wt_im == '0 &&
             res_re == {{(OW-DW){hold_mr[DW-1]}}, hold_mr} &&
             res_im == {{(OW-DW){hold_mi[DW-1]}}, hold_mi}));

endmodule

bind iq_canceller iqc_checker #(
    .DW(DW), .FRAC(FRAC), .WIN(WIN), .OW(OW), .WW(WW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .res_re    (res_re),
    .res_im    (res_im),
    .wt_re     (wt_re),
    .wt_im     (wt_im),
    .hold_mr   (hold_mr),
    .hold_mi   (hold_mi),
    .pw_sum    (acc_pw),
    .done0     (div_done[0]),
    .done1     (div_done[1])
);

// File: tb/iq_canceller_test.sv
// Bench for iq_canceller: a behavioural window model with queues and longints
// predicts each weight and residual; results are compared on every cycle.
module iq_canceller_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int FRAC = 10;
    localparam int WIN  = 9;
    localparam int OW   = DW + 4;
    localparam int WW   = 2 * DW + 6 + FRAC;
    localparam int NQ   = 2 * DW + 5 + FRAC;
    localparam int LAT  = NQ + 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] main_re = '0, main_im = '0, aux_re = '0, aux_im = '0;
    logic                 in_ready, out_valid;
    logic signed [OW-1:0] res_re, res_im;
    logic signed [WW-1:0] wt_re, wt_im;

    int tests = 0;
    int fails = 0;
    int n_acc = 0;
    int n_out = 0;
    bit finished = 0;

    longint h_mr[$], h_mi[$], h_ar[$], h_ai[$];
    longint e_rr[$], e_ri[$], e_wr[$], e_wi[$];
    string  e_tr[$], e_tw[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_canceller #(.DW(DW), .FRAC(FRAC), .WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .main_re(main_re), .main_im(main_im), .aux_re(aux_re), .aux_im(aux_im),
        .in_ready(in_ready), .out_valid(out_valid),
        .res_re(res_re), .res_im(res_im), .wt_re(wt_re), .wt_im(wt_im)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model: slide the window, form sums, weight and residual
    task automatic model_push(input longint mr, mi, ar, ai, input string tag_w, tag_r);
        longint nr, ni, p, wr, wi, er, ei;
        h_mr.push_front(mr); h_mi.push_front(mi);
        h_ar.push_front(ar); h_ai.push_front(ai);
        void'(h_mr.pop_back()); void'(h_mi.pop_back());
        void'(h_ar.pop_back()); void'(h_ai.pop_back());
        nr = 0; ni = 0; p = 0;
        for (int k = 0; k < WIN; k++) begin
            nr += h_mr[k] * h_ar[k] + h_mi[k] * h_ai[k];
            ni += h_mi[k] * h_ar[k] - h_mr[k] * h_ai[k];
            p  += h_ar[k] * h_ar[k] + h_ai[k] * h_ai[k];
        end
        if (p == 0) begin
            wr = 0; wi = 0;
        end else begin
            wr = (nr * (64'sd1 <<< FRAC)) / p;
            wi = (ni * (64'sd1 <<< FRAC)) / p;
        end
        er = wr * ar - wi * ai;
        ei = wr * ai + wi * ar;
        n_acc++;
        if (n_acc >= WIN) begin
            e_rr.push_back(mr - (er >>> FRAC));
            e_ri.push_back(mi - (ei >>> FRAC));
            e_wr.push_back(wr);
            e_wi.push_back(wi);
            e_tw.push_back(p == 0 ? "R5 R7 weight" : tag_w);
            e_tr.push_back(p == 0 ? "R5 R7 residual" : tag_r);
        end
    endtask

    // Compare every output pulse with the model
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (e_rr.size() == 0) begin
                chk("R3 unexpected out_valid", 1, 0);
            end else begin
                string tw, tr;
                tw = e_tw.pop_front();
                tr = e_tr.pop_front();
                chk(tw, longint'(wt_re), e_wr.pop_front());
                chk(tw, longint'(wt_im), e_wi.pop_front());
                chk(tr, longint'(res_re), e_rr.pop_front());
                chk(tr, longint'(res_im), e_ri.pop_front());
            end
        end
    end

    // Offer one pair, optionally pester the block while busy, time the result
    task automatic send(input logic signed [DW-1:0] mr, mi, ar, ai,
                        input string tag_w, tag_r, input bit junk);
        int lat;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        main_re = mr; main_im = mi; aux_re = ar; aux_im = ai;
        in_valid = 1'b1;
        model_push(mr, mi, ar, ai, tag_w, tag_r);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        chk("R2 ready low after accept", in_ready, 0);
        if (junk) begin
            main_re = 12'sd1999; main_im = -12'sd1777;
            aux_re = 12'sd1234;  aux_im = 12'sd321;
            in_valid = 1'b1;
            repeat (5) @(negedge clk);
            in_valid = 1'b0;
            lat += 5;
        end
        while (!in_ready) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency", lat, LAT);
    endtask

    function automatic logic signed [DW-1:0] rnd();
        return DW'($urandom);
    endfunction

    initial begin
        for (int k = 0; k < WIN; k++) begin
            h_mr.push_back(0); h_mi.push_back(0);
            h_ar.push_back(0); h_ai.push_back(0);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 res_re", res_re, 0);
        chk("R1 res_im", res_im, 0);
        chk("R1 wt_re", wt_re, 0);
        chk("R1 wt_im", wt_im, 0);

        // Random pairs; some with ignored offers while busy (R2)
        for (int k = 0; k < 14; k++)
            send(rnd(), rnd(), rnd(), rnd(), "R4 weight", "R6 residual R2", (k % 3) == 1);

        // Auxiliary silent: window flushes, power reaches zero (R5, R7)
        for (int k = 0; k < 12; k++)
            send(rnd(), rnd(), '0, '0, "R4 R7 weight", "R6 R7 residual", 1'b0);

        // Main is exactly twice the auxiliary: full cancellation once settled
        for (int k = 0; k < 12; k++) begin
            logic signed [DW-1:0] a0, a1;
            a0 = rnd() >>> 2;
            a1 = rnd() >>> 2;
            send(a0 <<< 1, a1 <<< 1, a0, a1, "R4 weight", "R6 residual", 1'b0);
        end

        // Full-scale values (R9)
        for (int k = 0; k < 12; k++) begin
            if (k % 2 == 0)
                send(-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048, "R9 weight", "R9 residual", 1'b0);
            else
                send(12'sd2047, -12'sd2048, -12'sd2048, 12'sd2047, "R9 weight", "R9 residual", 1'b0);
        end

        repeat (LAT + 5) @(negedge clk);
        chk("R3 output count", n_out, n_acc - (WIN - 1));
        chk("R3 pending results", e_rr.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule